// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns an active-low external interrupt line into a single interrupt request for a processor core. A dedicated interrupt pin and a group of port input pins are each passed through a synchroniser and then combined, so a low level on any one of them counts as an active line. A trigger state machine watches the combined line. It sets a request latch on a falling edge, or, when the level mode is chosen at reset, on a low level as well. The level mode lets several open-drain sources share one wire. Once set, the request stays pending until the core acknowledges the vector fetch or software writes the acknowledge bit. In level mode, if the line is still low after a clear, the request is raised again.

The trigger state machine has three states. `TRG_FILL` is entered on reset and lasts while the synchroniser fills, and no request can be set in it. It then moves to `TRG_DISARMED`, which means the line was last seen low. From `TRG_DISARMED` it moves to `TRG_ARMED` when the line is seen high. From `TRG_ARMED` it returns to `TRG_DISARMED` when the line is seen low, and that transition is a falling edge. The request latch has two states. `LAT_IDLE` moves to `LAT_PEND` on a set, and `LAT_PEND` returns to `LAT_IDLE` on a clear. When a set and a clear arrive in the same cycle, the clear wins.

A control register exposes three bits: the pending flag, an enable bit that masks the request to the core, and a write-one acknowledge bit.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset the register reads 0x00 and `irq_req_o` is 0. A line that is already low when reset is released does not set the flag in edge mode.
- R2: In edge mode, when the line falls from high to low, the flag (read bit 7) is 0 after two rising clock edges and 1 after the third.
- R3: In edge mode, a line held low never sets the flag again after a clear. A new request needs the line to return high and then fall.
- R4: In level mode, a low line sets the flag even when no falling edge was seen, including a line that is low when reset is released.
- R5: In level mode, if the line is still low when the flag is cleared, the flag reads 0 for one cycle and 1 from the next edge on. This holds while any source keeps the line low.
- R6: Each of the four port pins, when driven low on its own, acts exactly like the dedicated pin.
- R7: A pulse on `vec_fetch_i` clears the flag at that edge. A clear takes priority over a set in the same cycle.
- R8: Writing 1 to write bit 1 (acknowledge) clears the flag. Writing 0 there leaves the flag unchanged. The acknowledge bit always reads 0.
- R9: Write bit 0 / read bit 0 is the enable. `irq_req_o` is 1 only when both the flag and the enable are 1.
- R10: The mode input is sampled only while reset is asserted, with 1 selecting level mode and 0 edge mode. Changing it later has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the mode is captured while it is low |
| mode_level_i | input | 1 | 1 = edge-and-level trigger, 0 = edge-only trigger |
| irq_pin_n_i | input | 1 | Dedicated active-low interrupt pin (asynchronous) |
| port_pin_n_i | input | 4 | Port pins sharing the request, active low (asynchronous) |
| vec_fetch_i | input | 1 | Vector fetch acknowledge from the core, clears the flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 2 | Write data: bit 0 enable, bit 1 acknowledge |
| reg_rdata_o | output | 8 | Read data: bit 7 flag, bit 0 enable, all other bits 0 |
| irq_req_o | output | 1 | Interrupt request to the core |

## Verification
The assertions check on every cycle that:
- a clear always empties the latch;
- a set without a clear fills the latch;
- a pending request holds until it is cleared;
- a falling edge is flagged only right after the line was seen high, and never two cycles in a row;
- the captured mode never moves after reset;
- the request output never rises without both the flag and the enable set.

Only the bench scenarios can show the rest:
- the exact three-edge latency;
- the need for a return to high in edge mode;
- the one-cycle gap before a level request is raised again;
- the shared line built from the four port pins;
- the behaviour of the acknowledge bit;
- that the mode input is ignored once reset is released.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        TRG_FILL     = 2'd0,
        TRG_DISARMED = 2'd1,
        TRG_ARMED    = 2'd2
    } trg_state_e;

    typedef enum logic {
        LAT_IDLE = 1'b0,
        LAT_PEND = 1'b1
    } lat_state_e;

    localparam int REG_W     = 8;
    localparam int WR_W      = 2;
    localparam int BIT_EN    = 0;
    localparam int BIT_ACK   = 1;
    localparam int BIT_FLAG  = 7;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    // Each bit gets its own chain; reset value is the inactive (high) level.
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
        end
        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger
    import ext_irq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_level_i,
    input  logic line_high_i,
    output logic fall_o,
    output logic set_o
);
    localparam int CNT_W = $clog2(STAGES + 1);
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(STAGES - 1);

    trg_state_e       state_q, state_d;
    logic [CNT_W-1:0] fill_cnt_q;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= TRG_FILL;
            fill_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TRG_FILL) begin
                fill_cnt_q <= fill_cnt_q + CNT_W'(1);
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRG_FILL:     if (fill_cnt_q == FILL_LAST) state_d = TRG_DISARMED;
            TRG_DISARMED: if (line_high_i)             state_d = TRG_ARMED;
            TRG_ARMED:    if (!line_high_i)            state_d = TRG_DISARMED;
            default:                                   state_d = TRG_FILL;
        endcase
    end

    // Output process
    always_comb begin
        fall_o = 1'b0;
        set_o  = 1'b0;
        unique case (state_q)
            TRG_FILL: begin
                fall_o = 1'b0;
                set_o  = 1'b0;
            end
            TRG_DISARMED: begin
                fall_o = 1'b0;
                set_o  = mode_level_i && !line_high_i;
            end
            TRG_ARMED: begin
                fall_o = !line_high_i;
                set_o  = !line_high_i;
            end
            default: begin
                fall_o = 1'b0;
                set_o  = 1'b0;
            end
        endcase
    end

    // R3: an edge is reported only after the line was seen high
    a_r3_edge_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> $past(line_high_i));

    // R3: a held-low line yields one edge only
    a_r3_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/ext_irq_req_latch.sv
module ext_irq_req_latch
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    lat_state_e state_q, state_d;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LAT_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic: clear has priority
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAT_IDLE: if (set_i && !clr_i) state_d = LAT_PEND;
            LAT_PEND: if (clr_i)           state_d = LAT_IDLE;
            default:                       state_d = LAT_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        pend_o = (state_q == LAT_PEND);
    end

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !pend_o);

    a_r2_set_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> pend_o);

    a_r7_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);

endmodule

// File: rtl/ext_irq_ctrl_reg.sv
module ext_irq_ctrl_reg
    import ext_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [WR_W-1:0] wdata_i,
    input  logic            pend_i,
    output logic            en_o,
    output logic            ack_o,
    output logic [REG_W-1:0] rdata_o
);
    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    en_q <= 1'b0;
        else if (wr_i) en_q <= wdata_i[BIT_EN];
    end

    always_comb begin
        ack_o             = wr_i && wdata_i[BIT_ACK];
        en_o              = en_q;
        rdata_o           = '0;
        rdata_o[BIT_EN]   = en_q;
        rdata_o[BIT_FLAG] = pend_i;
    end

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !rdata_o[BIT_FLAG]);

endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
    import ext_irq_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_level_i,
    input  logic             irq_pin_n_i,
    input  logic [NPORT-1:0] port_pin_n_i,
    input  logic             vec_fetch_i,
    input  logic             reg_wr_i,
    input  logic [WR_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             irq_req_o
);
    localparam int NIN = NPORT + 1;

    logic           mode_q;
    logic [NIN-1:0] sync_n;
    logic           line_high;
    logic           fall, set_req, pend, en, ack;

    // Mode is loaded only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= mode_level_i;
    end

    ext_irq_sync #(.W(NIN), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({port_pin_n_i, irq_pin_n_i}),
        .sync_o (sync_n)
    );

    // Wired combination: any low input makes the line low
    assign line_high = &sync_n;

    ext_irq_trigger #(.STAGES(STAGES)) u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_level_i(mode_q),
        .line_high_i (line_high),
        .fall_o      (fall),
        .set_o       (set_req)
    );

    ext_irq_req_latch u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_req),
        .clr_i (vec_fetch_i || ack),
        .pend_o(pend)
    );

    ext_irq_ctrl_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr_i),
        .wdata_i(reg_wdata_i),
        .pend_i (pend),
        .en_o   (en),
        .ack_o  (ack),
        .rdata_o(reg_rdata_o)
    );

    assign irq_req_o = pend && en;

    a_r10_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_q));

    a_r9_req_needs_flag_and_en: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (reg_rdata_o[BIT_FLAG] && reg_rdata_o[BIT_EN]));

    a_r5_level_relatch: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && set_req && !vec_fetch_i && !ack) |=> reg_rdata_o[BIT_FLAG]);

endmodule

// File: tb/ext_irq_latch_tb.sv
module ext_irq_latch_tb;

    typedef struct {
        string      req;
        logic [7:0] rd;
        logic       irq;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       pin_n = 1'b1;
    logic [3:0] port_n = 4'hF;
    logic       vf = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] wdata = 2'b00;
    logic [7:0] rdata;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    ext_irq_latch u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_level_i(mode),
        .irq_pin_n_i (pin_n),
        .port_pin_n_i(port_n),
        .vec_fetch_i (vf),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_req_o   (irq)
    );

    // Monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_tests++;
            if (rdata !== it.rd || irq !== it.irq) begin
                n_fail++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         it.req, rdata, irq, it.rd, it.irq);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic [7:0] rd, input logic ir);
        sb_item_t it;
        it.req = req; it.rd = rd; it.irq = ir;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input logic m);
        rst_n = 1'b0;
        mode  = m;
        tick(4);
        rst_n = 1'b1;
        tick(6);
    endtask

    task automatic reg_write(input logic [1:0] d);
        wr = 1'b1; wdata = d;
        tick(1);
        wr = 1'b0; wdata = 2'b00;
    endtask

    task automatic fetch_pulse();
        vf = 1'b1;
        tick(1);
        vf = 1'b0;
    endtask

    initial begin
        // Edge mode, line low across reset
        pin_n = 1'b0;
        do_reset(1'b0);
        expect_out("R1", 8'h00, 1'b0);
        pin_n = 1'b1;
        tick(4);
        expect_out("R1", 8'h00, 1'b0);

        // Exact edge latency
        pin_n = 1'b0;
        tick(2);
        expect_out("R2", 8'h00, 1'b0);
        tick(1);
        expect_out("R2", 8'h80, 1'b0);

        // Enable masking
        reg_write(2'b01);
        expect_out("R9", 8'h81, 1'b1);
        reg_write(2'b00);
        expect_out("R9", 8'h80, 1'b0);
        reg_write(2'b01);

        // Acknowledge
        reg_write(2'b01);
        expect_out("R8", 8'h81, 1'b1);
        reg_write(2'b11);
        expect_out("R8", 8'h01, 1'b0);

        // Held low does not retrigger; needs high then low
        tick(6);
        expect_out("R3", 8'h01, 1'b0);
        pin_n = 1'b1;
        tick(6);
        expect_out("R3", 8'h01, 1'b0);
        pin_n = 1'b0;
        tick(4);
        expect_out("R3", 8'h81, 1'b1);

        // Vector fetch clears
        fetch_pulse();
        expect_out("R7", 8'h01, 1'b0);
        tick(5);
        expect_out("R3", 8'h01, 1'b0);

        // Mode input ignored after reset
        mode = 1'b1;
        tick(6);
        expect_out("R10", 8'h01, 1'b0);
        mode = 1'b0;
        pin_n = 1'b1;
        tick(4);

        // Port pins, one at a time
        for (int i = 0; i < 4; i++) begin
            port_n[i] = 1'b0;
            tick(4);
            expect_out("R6", 8'h81, 1'b1);
            reg_write(2'b11);
            port_n[i] = 1'b1;
            tick(4);
            expect_out("R6", 8'h01, 1'b0);
        end

        // Level mode, line low across reset
        pin_n = 1'b0;
        do_reset(1'b1);
        expect_out("R4", 8'h80, 1'b0);
        reg_write(2'b01);
        expect_out("R4", 8'h81, 1'b1);

        // Relatch after a vector-fetch clear
        fetch_pulse();
        expect_out("R7", 8'h01, 1'b0);
        tick(1);
        expect_out("R5", 8'h81, 1'b1);

        // Wired-OR: second source keeps the request alive
        port_n[0] = 1'b0;
        pin_n = 1'b1;
        tick(4);
        reg_write(2'b11);
        expect_out("R5", 8'h01, 1'b0);
        tick(1);
        expect_out("R5", 8'h81, 1'b1);
        port_n[0] = 1'b1;
        tick(4);
        reg_write(2'b11);
        tick(4);
        expect_out("R5", 8'h01, 1'b0);

        // Clear wins over a simultaneous set
        pin_n = 1'b0;
        tick(4);
        vf = 1'b1;
        tick(2);
        vf = 1'b0;
        expect_out("R7", 8'h01, 1'b0);
        tick(1);
        expect_out("R7", 8'h81, 1'b1);

        tick(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule